// File: doc/BRIEF.md
# Text-Mode Character Glyph Expander

This block turns text-mode frame buffer contents into a stream of 4-bit pixel indices. It works on one character cell per character period. A character period lasts eight dot clocks, or nine when the wide-cell option is set. For each cell it makes two dependent reads on a single memory port. The first read returns a 32-bit word whose lowest byte is the character code and whose next byte is the attribute. The second read uses an address built from the font base, the character code and the current glyph scan line. That word returns the glyph row in its third byte. The glyph row is then serialized, most significant bit first, with one pixel per dot clock. A set bit gives the foreground colour and a clear bit gives the background colour.

The block runs one scan line at a time. A line begins with a start pulse and covers a programmed number of cells. All scan lines of a character row read the same cell addresses; only the glyph scan line changes. Once the last cell of a line has been fetched, the glyph line counter advances. When the counter passes the programmed height, it wraps to zero, a row-advance pulse is raised, and the row base address steps forward by the pitch. A frame-start pulse sets the row base to the start address and the glyph line to zero. Palette lookup, display timing and memory arbitration are done elsewhere. The memory is assumed to return read data in the cycle after the read strobe.

Top module: `gx_text_expander`

## Requirements
- R1: While reset is held, mem_rd, pix_valid, row_adv and line_busy are 0 and glyph_line is 0.
- R2: Count the cycles of an accepted line from i = 0, the cycle after the start pulse is taken. With P = 8 (or 9 when cfg_nine_dot = 1), k = i / P and d = i mod P, cycle d = 0 of period k (k < cfg_cols) issues mem_rd with mem_addr = row base + k. Every scan line of a character row uses the same row base.
- R3: Cycle d = 2 of period k issues mem_rd with mem_addr = {cfg_font_base, code, glyph_line}, where code is bits [7:0] of the word returned for that cell's read. No other cycle of the line asserts mem_rd.
- R4: Pixel j (j < 8) of cell k appears with pix_valid = 1 in cycle i = (k+1)·P + j. It equals attribute bits [3:0] when bit 7−j of the glyph byte is 1, and attribute bits [7:4] otherwise. The attribute is bits [15:8] of the cell word; the glyph byte is bits [23:16] of the font word.
- R5: With cfg_nine_dot = 1 the period is 9 cycles, and pixel 8 of every cell is always the background colour (attribute bits [7:4]).
- R6: After the fetch of a line's last cell, glyph_line increments in cycle i = cfg_cols·P. If it was equal to cfg_height_m1, it instead wraps to 0, row_adv is 1 for exactly that cycle, and the row base grows by cfg_pitch.
- R7: One cycle after frame_start, glyph_line is 0, and the next line reads its cells from cfg_start.
- R8: A line_start that arrives while line_busy is 1, or while cfg_cols is 0, is ignored. It changes neither reads, pixels nor counters.
- R9: pix_valid is 0 outside the pixel windows of R4, and in particular during the first character period of a line that follows an idle stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low reset |
| cfg_nine_dot | input | 1 | 1 = nine-dot cells, 0 = eight-dot cells |
| cfg_height_m1 | input | LINE_W | Character height minus one |
| cfg_cols | input | COL_W | Cells per scan line |
| cfg_pitch | input | AW | Row base increment per character row |
| cfg_start | input | AW | Row base loaded at frame start |
| cfg_font_base | input | FONT_BASE_W | Upper bits of the font address |
| frame_start | input | 1 | Restart rows and glyph lines |
| line_start | input | 1 | Begin one scan line |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| pix_valid | output | 1 | Pixel strobe |
| pix_index | output | 4 | Pixel colour index |
| glyph_line | output | LINE_W | Current scan line within the character row |
| row_adv | output | 1 | One-cycle pulse when a row completes |
| line_busy | output | 1 | A scan line is being fetched |

## Verification
Several corner cases are targeted directly. The glyph line wrap is tested at heights of 1 and 32. A design with an off-by-one compare would either skip the row-advance pulse or repeat the last glyph line. Nine-dot cells check that the extra pixel shows the background colour; a design that keeps shifting would show a foreground or stale bit instead. A start pulse is sent in the middle of a line, and another with zero columns, to prove that neither one restarts the sequencer or moves the counters. Lines in consecutive character rows are compared address by address, to catch a design that forgets to reuse the row base or that steps it on every line.

// File: rtl/gx_pkg.sv
package gx_pkg;

  localparam int DOT_W = 4;

  typedef struct packed {
    logic [7:0] attr;
    logic [7:0] code;
  } cell_t;

  // index of the final dot of a character period
  function automatic logic [DOT_W-1:0] last_dot(input logic nine);
    return nine ? DOT_W'(8) : DOT_W'(7);
  endfunction

  // colour for one dot: foreground in attr[3:0], background in attr[7:4]
  function automatic logic [3:0] dot_colour(input logic lit, input logic extra,
                                            input logic [7:0] attr);
    if (extra) return attr[7:4];
    return lit ? attr[3:0] : attr[7:4];
  endfunction

endpackage

// File: rtl/gx_char_timer.sv
module gx_char_timer #(
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nine,
  input  logic [COL_W-1:0] cols,
  input  logic             line_start,
  output logic             busy,
  output logic [COL_W-1:0] col,
  output logic             ev_cell_rd,
  output logic             ev_cell_cap,
  output logic             ev_font_rd,
  output logic             ev_font_cap,
  output logic             ev_load,
  output logic             ev_line_end
);
  import gx_pkg::*;

  logic [DOT_W-1:0] dot;
  logic             at_last;
  logic             take;

  assign at_last = (dot == last_dot(nine));
  assign take    = line_start && !busy && (cols != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      dot  <= '0;
      col  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      dot  <= '0;
      col  <= '0;
    end else if (busy) begin
      if (at_last) begin
        dot <= '0;
        if (col == cols - 1'b1) busy <= 1'b0;
        else                    col  <= col + 1'b1;
      end else begin
        dot <= dot + 1'b1;
      end
    end
  end

  assign ev_cell_rd  = busy && (dot == DOT_W'(0));
  assign ev_cell_cap = busy && (dot == DOT_W'(1));
  assign ev_font_rd  = busy && (dot == DOT_W'(2));
  assign ev_font_cap = busy && (dot == DOT_W'(3));
  assign ev_load     = busy && at_last;
  assign ev_line_end = busy && at_last && (col == cols - 1'b1);

endmodule

// File: rtl/gx_row_track.sv
module gx_row_track #(
  parameter int LINE_W = 5,
  parameter int AW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_end,
  input  logic [LINE_W-1:0] height_m1,
  input  logic [AW-1:0]     pitch,
  input  logic [AW-1:0]     start,
  output logic [LINE_W-1:0] glyph_line,
  output logic [AW-1:0]     row_addr,
  output logic              row_adv
);

  logic wrap;
  assign wrap = (glyph_line == height_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glyph_line <= '0;
      row_addr   <= '0;
      row_adv    <= 1'b0;
    end else begin
      row_adv <= 1'b0;
      if (frame_start) begin
        glyph_line <= '0;
        row_addr   <= start;
      end else if (line_end) begin
        if (wrap) begin
          glyph_line <= '0;
          row_addr   <= row_addr + pitch;
          row_adv    <= 1'b1;
        end else begin
          glyph_line <= glyph_line + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/gx_shifter.sv
module gx_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nine,
  input  logic       load,
  input  logic [7:0] glyph,
  input  logic [7:0] attr,
  output logic       pix_valid,
  output logic [3:0] pix_index
);
  import gx_pkg::*;

  logic [7:0]       shreg;
  logic [7:0]       attr_q;
  logic [DOT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      attr_q <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= glyph;
      attr_q <= attr;
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == last_dot(nine)) begin
        active <= 1'b0;
      end else begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[6:0], 1'b0};
      end
    end
  end

  assign pix_valid = active;
  assign pix_index = active ? dot_colour(shreg[7], cnt[3], attr_q) : 4'd0;

endmodule

// File: rtl/gx_text_expander.sv
module gx_text_expander #(
  parameter int FONT_BASE_W = 3,
  parameter int COL_W       = 7,
  parameter int LINE_W      = 5,
  localparam int AW         = FONT_BASE_W + 8 + LINE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_nine_dot,
  input  logic [LINE_W-1:0]      cfg_height_m1,
  input  logic [COL_W-1:0]       cfg_cols,
  input  logic [AW-1:0]          cfg_pitch,
  input  logic [AW-1:0]          cfg_start,
  input  logic [FONT_BASE_W-1:0] cfg_font_base,
  input  logic                   frame_start,
  input  logic                   line_start,
  output logic                   mem_rd,
  output logic [AW-1:0]          mem_addr,
  input  logic [31:0]            mem_rdata,
  output logic                   pix_valid,
  output logic [3:0]             pix_index,
  output logic [LINE_W-1:0]      glyph_line,
  output logic                   row_adv,
  output logic                   line_busy
);
  import gx_pkg::*;

  function automatic logic [AW-1:0] font_addr(input logic [FONT_BASE_W-1:0] base,
                                              input logic [7:0] code,
                                              input logic [LINE_W-1:0] line);
    return {base, code, line};
  endfunction

  function automatic logic [AW-1:0] cell_addr(input logic [AW-1:0] base,
                                              input logic [COL_W-1:0] col);
    return base + AW'(col);
  endfunction

  logic [COL_W-1:0] cur_col;
  logic [AW-1:0]    row_addr;
  logic             ev_cell_rd, ev_cell_cap, ev_font_rd, ev_font_cap;
  logic             ev_load, ev_line_end;
  cell_t            cell_q;
  logic [7:0]       glyph_q;

  gx_char_timer #(.COL_W(COL_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .nine        (cfg_nine_dot),
    .cols        (cfg_cols),
    .line_start  (line_start),
    .busy        (line_busy),
    .col         (cur_col),
    .ev_cell_rd  (ev_cell_rd),
    .ev_cell_cap (ev_cell_cap),
    .ev_font_rd  (ev_font_rd),
    .ev_font_cap (ev_font_cap),
    .ev_load     (ev_load),
    .ev_line_end (ev_line_end)
  );

  gx_row_track #(.LINE_W(LINE_W), .AW(AW)) u_rows (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_end    (ev_line_end),
    .height_m1   (cfg_height_m1),
    .pitch       (cfg_pitch),
    .start       (cfg_start),
    .glyph_line  (glyph_line),
    .row_addr    (row_addr),
    .row_adv     (row_adv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q  <= '0;
      glyph_q <= '0;
    end else begin
      if (ev_cell_cap) cell_q  <= cell_t'(mem_rdata[15:0]);
      if (ev_font_cap) glyph_q <= mem_rdata[23:16];
    end
  end

  always_comb begin
    mem_rd   = ev_cell_rd | ev_font_rd;
    mem_addr = '0;
    if (ev_cell_rd)      mem_addr = cell_addr(row_addr, cur_col);
    else if (ev_font_rd) mem_addr = font_addr(cfg_font_base, cell_q.code, glyph_line);
  end

  gx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .nine      (cfg_nine_dot),
    .load      (ev_load),
    .glyph     (glyph_q),
    .attr      (cell_q.attr),
    .pix_valid (pix_valid),
    .pix_index (pix_index)
  );

endmodule

// File: rtl/gx_text_expander_chk.sv
module gx_text_expander_chk #(
  parameter int LINE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              line_busy,
  input logic              row_adv,
  input logic [LINE_W-1:0] glyph_line,
  input logic              frame_start,
  input logic              pix_valid,
  input logic              ev_load
);

  assert_rd_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_rd_in_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> line_busy);

  assert_adv_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |=> !row_adv);

  assert_adv_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |-> glyph_line == '0);

  assert_line_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(glyph_line) && !$past(frame_start)) |->
      (glyph_line == $past(glyph_line) + 1'b1) || (glyph_line == '0));

  assert_frame_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (glyph_line == '0) && !row_adv);

  assert_load_shows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> pix_valid);

endmodule

bind gx_text_expander gx_text_expander_chk #(.LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .line_busy   (line_busy),
  .row_adv     (row_adv),
  .glyph_line  (glyph_line),
  .frame_start (frame_start),
  .pix_valid   (pix_valid),
  .ev_load     (ev_load)
);

// File: tb/sim_gx_text_expander.sv
`timescale 1ns/1ps
module sim_gx_text_expander;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_nine_dot = 1'b0;
  logic [4:0]  cfg_height_m1 = 5'd2;
  logic [6:0]  cfg_cols = 7'd4;
  logic [15:0] cfg_pitch = 16'd80;
  logic [15:0] cfg_start = 16'd0;
  logic [2:0]  cfg_font_base = 3'd5;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        pix_valid;
  logic [3:0]  pix_index;
  logic [4:0]  glyph_line;
  logic        row_adv;
  logic        line_busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [4:0]  m_line = '0;
  logic [15:0] m_row = '0;

  always #10 clk = ~clk;

  gx_text_expander u0 (.*);

  // memory contents derived from the address
  function automatic logic [7:0] h_code(input logic [15:0] a);
    return a[7:0] * 8'd37 + a[15:8];
  endfunction
  function automatic logic [7:0] h_attr(input logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h96;
  endfunction
  function automatic logic [7:0] h_glyph(input logic [15:0] a);
    return a[12:5] ^ {a[4:0], a[15:13]};
  endfunction

  logic [15:0] rd_q = '0;
  always @(posedge clk) if (mem_rd) rd_q <= mem_addr;
  assign mem_rdata = {8'hC3, h_glyph(rd_q), h_attr(rd_q), h_code(rd_q)};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  // runs one line, checking reads and pixels every cycle
  task automatic run_line(input int cols, input bit mid_pulse);
    int p = cfg_nine_dot ? 9 : 8;
    bit wraps = (m_line == cfg_height_m1);
    cfg_cols = 7'(cols);
    line_start = 1'b1;
    @(posedge clk);
    for (int i = 0; i < (cols + 1) * p; i++) begin
      int k = i / p;
      int d = i % p;
      @(negedge clk);
      line_start = 1'b0;
      if (k < cols) begin
        logic [15:0] ca = m_row + 16'(k);
        if (d == 0) begin
          chk(mem_rd && mem_addr == ca, "R2 cell read", mem_addr, ca);
        end else if (d == 2) begin
          logic [15:0] fa = {cfg_font_base, h_code(ca), m_line};
          chk(mem_rd && mem_addr == fa, "R3 font read", mem_addr, fa);
        end else begin
          chk(!mem_rd, "R3 idle read", mem_rd, 0);
        end
      end
      if (k == 0) begin
        chk(!pix_valid, "R9 no pixel before load", pix_valid, 0);
      end else begin
        logic [15:0] pa = m_row + 16'(k - 1);
        logic [7:0] at = h_attr(pa);
        logic [7:0] gl = h_glyph({cfg_font_base, h_code(pa), m_line});
        logic [3:0] ex = (d == 8) ? at[7:4] : (gl[7 - d] ? at[3:0] : at[7:4]);
        chk(pix_valid && pix_index == ex, d == 8 ? "R5 ninth pixel" : "R4 pixel",
            pix_index, ex);
      end
      if (i == cols * p) begin
        logic [4:0] nl = wraps ? 5'd0 : m_line + 5'd1;
        chk(glyph_line == nl, "R6 glyph line step", glyph_line, nl);
        chk(row_adv == wraps, "R6 row advance pulse", row_adv, wraps);
        chk(!line_busy, "R6 line done", line_busy, 0);
      end
      if (mid_pulse && i == 4) line_start = 1'b1;
    end
    @(negedge clk);
    chk(!pix_valid && !mem_rd, "R9 quiet after line", pix_valid, 0);
    if (wraps) begin
      m_line = '0;
      m_row  = m_row + cfg_pitch;
    end else begin
      m_line = m_line + 5'd1;
    end
  endtask

  task automatic do_frame(input logic [15:0] start);
    cfg_start = start;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(glyph_line == 5'd0, "R7 frame clears line", glyph_line, 0);
    m_line = '0;
    m_row  = start;
  endtask

  task automatic t_reset;
    #5;
    chk(!mem_rd && !pix_valid && !row_adv && !line_busy && glyph_line == 0,
        "R1 reset state", {mem_rd, pix_valid, row_adv, line_busy}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_rows;
    cfg_nine_dot = 1'b0;
    cfg_height_m1 = 5'd2;
    cfg_pitch = 16'd80;
    do_frame(16'h0120);
    for (int n = 0; n < 7; n++) run_line(4, 1'b0);
    do_frame(16'h0040);
    run_line(3, 1'b0);
  endtask

  task automatic t_nine;
    cfg_nine_dot = 1'b1;
    cfg_font_base = 3'd2;
    cfg_height_m1 = 5'd1;
    do_frame(16'h0300);
    for (int n = 0; n < 3; n++) run_line(3, 1'b0);
    cfg_nine_dot = 1'b0;
  endtask

  task automatic t_ignore;
    logic [4:0] gl0;
    cfg_height_m1 = 5'd3;
    do_frame(16'h0555);
    run_line(5, 1'b1);
    run_line(2, 1'b1);
    gl0 = glyph_line;
    cfg_cols = 7'd0;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int n = 0; n < 12; n++) begin
      chk(!line_busy && !mem_rd && !pix_valid, "R8 zero-column start ignored",
          {line_busy, mem_rd, pix_valid}, 0);
      @(negedge clk);
    end
    chk(glyph_line == gl0, "R8 line count kept", glyph_line, gl0);
    run_line(2, 1'b0);
  endtask

  task automatic t_heights;
    cfg_height_m1 = 5'd0;
    cfg_font_base = 3'd7;
    do_frame(16'h0010);
    for (int n = 0; n < 3; n++) run_line(1, 1'b0);
    cfg_height_m1 = 5'd31;
    do_frame(16'h0700);
    for (int n = 0; n < 33; n++) run_line(1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_rows();
    t_nine();
    t_ignore();
    t_heights();
    report();
  end

endmodule